// File: doc/BRIEF.md
# Streaming 2D Stencil Processing Element

This block performs one time step of a radius-R cross-shaped stencil over a 2D grid of 16-bit signed fixed-point cells. The grid is cut along x into overlapping blocks of fixed width; one block is streamed in row by row, V adjacent cells per beat, over a valid/ready input. Rows already seen are held in an on-chip shift register, so every input cell enters the element exactly once. For each beat, the element produces V updated cells on a valid/ready output, together with a per-lane flag that says whether each result can be trusted.

Every output cell is the centre cell times its own weight plus, for each distance d from 1 to R, the west, east, north and south neighbours at that distance, each with an independent weight. Lanes near the block's left and right edges are computed but flagged untrusted, because their neighbours belong to the next block. Adjacent blocks therefore only need to overlap by that halo. Several elements can be chained, one per time step. A cell that arrives flagged untrusted also makes every result that reads it untrusted, so the untrusted margin widens by R cells per stage.

Top module: `stencil_pe`

## Requirements
- R1: The coefficient port holds 4R+1 signed Q1.14 weights of CW bits each. Slot 0 weights the centre. For distance d (1..R), slot 4(d-1)+1 weights west, +2 east, +3 north and +4 south. An interior result is the rounded weighted sum of those taps.
- R2: Products are accumulated at full width. The sum is rounded by adding 2^13 and shifting right arithmetically by 14, then saturated to the range -32768..32767.
- R3: In an interior row, a west or east neighbour that lies left of block column 0, right of column BLK_W-1, left of grid column 0 or at or beyond grid column GRID_W is replaced by the centre cell's value.
- R4: The first R rows and the last R rows of the grid leave the element with their input value unchanged.
- R5: A lane's valid bit is 0 when its block column is below R or at or above BLK_W-R, or when its grid column (block origin plus block column) lies outside 0..GRID_W-1.
- R6: An interior result is valid only if the input valid bits of its centre and of every neighbour it actually reads were all 1. Edge-row results follow only the centre's input bit.
- R7: Output beats appear in the order the input beats arrived, exactly one output beat per input beat. In-lane order is kept: bits [l*16 +: 16] carry block column beat*V+l. With a free-running output, the first result becomes visible after R*(BLK_W/V)+3 beats have been accepted.
- R8: While out_valid is high and out_ready is low, the output beat stays unchanged and in_ready is low. No result is lost or repeated under any backpressure pattern.
- R9: The block origin is sampled together with the first beat of a block, and later changes of blk_x0 within the block have no effect. After the block's last beat is accepted, in_ready stays low while the element drains its remaining results.
- R10: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted this cycle when both are high |
| in_data | input | V*DW | V adjacent cells, lane 0 leftmost |
| in_mask | input | V | Per-lane trust flag of the incoming cells |
| blk_x0 | input | XW | Signed grid column of block column 0, taken with the first beat |
| coef | input | (4R+1)*CW | Per-tap Q1.14 weights, slot order as in R1 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | V*DW | V updated cells |
| out_mask | output | V | Per-lane result trust flag |

## Verification
The hardest situation to reach from the ports is output backpressure that lands while the element is draining the tail of a block and turning over to the next one. This is where input intake must stay closed and the held output must not be overwritten. The stimulus table streams several blocks back to back with periodic gaps on both in_valid and out_ready, so stalls fall on the drain and the restart. A separate run injects one untrusted cell to follow how the flag spreads to its four neighbours. Another run resets in the middle of a block to confirm the element starts cleanly afterwards.

// File: rtl/stencil_pkg.sv
// Shared helpers for the stencil element: tap slot numbering of the
// coefficient and neighbour vectors. Assumes radius distances start at 1.
package stencil_pkg;

    // Slot of the west tap at distance d inside the neighbour vector (centre excluded).
    function automatic int slot_w(input int d);
        return 4 * (d - 1);
    endfunction

    // Slot of the east tap at distance d.
    function automatic int slot_e(input int d);
        return 4 * (d - 1) + 1;
    endfunction

    // Slot of the north tap at distance d.
    function automatic int slot_n(input int d);
        return 4 * (d - 1) + 2;
    endfunction

    // Slot of the south tap at distance d.
    function automatic int slot_s(input int d);
        return 4 * (d - 1) + 3;
    endfunction

endpackage

// File: rtl/stencil_rowbuf.sv
// Beat-wide shift register holding 2*R block rows plus two beats.
// On every shift the newest beat enters stage 0. It exposes the beats a
// centre beat needs: the centre itself, its west and east beats, and the
// beats R rows above and below. Assumes every row has NB beats.
module stencil_rowbuf #(
    parameter int BW = 34,
    parameter int R  = 1,
    parameter int NB = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift,
    input  logic [BW-1:0]           din,
    output logic [(3+2*R)*BW-1:0]   win
);
    localparam int DEPTH = 2 * R * NB + 2;
    localparam int CTR   = R * NB + 1;

    logic [BW-1:0] stage [DEPTH];

    // Advance the whole chain by one beat when a shift is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
        end else if (shift) begin
            stage[0] <= din;
            for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
        end
    end

    assign win[0*BW +: BW] = stage[CTR];
    assign win[1*BW +: BW] = stage[CTR+1];
    assign win[2*BW +: BW] = stage[CTR-1];

    for (genvar d = 1; d <= R; d++) begin : g_rows
        assign win[(1+2*d)*BW +: BW] = stage[CTR + d*NB];
        assign win[(2+2*d)*BW +: BW] = stage[CTR - d*NB];
    end
endmodule

// File: rtl/stencil_lane.sv
// One output lane: clamps unusable neighbours to the centre value, forms
// the Q1.14 weighted sum, rounds and saturates, and derives the trust flag.
// Assumes CW-2 fraction bits in the weights.
module stencil_lane #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int R  = 1
) (
    input  logic [DW-1:0]           ctr,
    input  logic                    ctr_ok,
    input  logic [4*R*DW-1:0]       nbr,
    input  logic [4*R-1:0]          nbr_ok,
    input  logic [4*R-1:0]          nbr_in,
    input  logic                    edge_row,
    input  logic                    lane_ok,
    input  logic [(4*R+1)*CW-1:0]   coef,
    output logic [DW-1:0]           res,
    output logic                    res_ok
);
    localparam int NTAP  = 4 * R + 1;
    localparam int PW    = DW + CW;
    localparam int ACC_W = PW + $clog2(NTAP) + 1;
    localparam int FRAC  = CW - 2;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    // Multiply-accumulate all taps, then round, saturate and merge trust flags.
    always_comb begin
        logic signed [DW-1:0]    v;
        logic signed [CW-1:0]    k;
        logic signed [PW-1:0]    prod;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] q;
        logic                    ok;
        v    = $signed(ctr);
        k    = $signed(coef[0 +: CW]);
        prod = PW'(v) * PW'(k);
        acc  = ACC_W'(prod);
        ok   = ctr_ok & lane_ok;
        for (int t = 0; t < 4*R; t++) begin
            v    = nbr_in[t] ? $signed(nbr[t*DW +: DW]) : $signed(ctr);
            k    = $signed(coef[(t+1)*CW +: CW]);
            prod = PW'(v) * PW'(k);
            acc  = acc + ACC_W'(prod);
            if (nbr_in[t]) ok = ok & nbr_ok[t];
        end
        q = (acc + (ACC_W'(1) <<< (FRAC - 1))) >>> FRAC;
        if (edge_row) begin
            res    = ctr;
            res_ok = ctr_ok & lane_ok;
        end else begin
            if (q > MAXV)      res = MAXV[DW-1:0];
            else if (q < MINV) res = MINV[DW-1:0];
            else               res = q[DW-1:0];
            res_ok = ok;
        end
    end
endmodule

// File: rtl/stencil_pe.sv
// Streaming radius-R 2D stencil element for one block of BLK_W columns
// and GRID_H rows, V cells per beat. It assumes that BLK_W is a multiple
// of V, that V >= R and that BLK_W > 2*R. After the last input beat it
// drains the remaining results on its own, then accepts the next block.
module stencil_pe
    import stencil_pkg::*;
#(
    parameter int DW     = 16,
    parameter int CW     = 16,
    parameter int V      = 2,
    parameter int R      = 1,
    parameter int BLK_W  = 8,
    parameter int GRID_W = 12,
    parameter int GRID_H = 5,
    parameter int XW     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [V*DW-1:0]         in_data,
    input  logic [V-1:0]            in_mask,
    input  logic signed [XW-1:0]    blk_x0,
    input  logic [(4*R+1)*CW-1:0]   coef,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [V*DW-1:0]         out_data,
    output logic [V-1:0]            out_mask
);
    localparam int NB     = BLK_W / V;
    localparam int TOT    = GRID_H * NB;
    localparam int FILL   = R * NB + 2;
    localparam int LAST   = TOT + FILL;
    localparam int BW     = V * DW + V;
    localparam int CNT_W  = $clog2(LAST + 1);
    localparam int ROW_W  = $clog2(GRID_H + 1);
    localparam int BEAT_W = $clog2(NB + 1);

    logic [CNT_W-1:0]          sh_cnt;
    logic signed [XW-1:0]      x0_q;
    logic [ROW_W-1:0]          orow;
    logic [BEAT_W-1:0]         obeat;
    logic                      adv, feeding, shift, emit, edge_row;
    logic [BW-1:0]             din;
    logic [(3+2*R)*BW-1:0]     win;
    logic [V*DW-1:0]           res_n;
    logic [V-1:0]              ok_n;

    assign adv      = !out_valid || out_ready;
    assign feeding  = sh_cnt < CNT_W'(TOT);
    assign in_ready = adv && feeding;
    assign shift    = adv && (feeding ? in_valid : 1'b1);
    assign emit     = shift && (sh_cnt >= CNT_W'(FILL));
    assign din      = feeding ? {in_mask, in_data} : '0;
    assign edge_row = (int'(orow) < R) || (int'(orow) >= GRID_H - R);

    // Count shifts through one block (fill, stream, drain) and latch the origin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cnt <= '0;
            x0_q   <= '0;
        end else if (shift) begin
            if (sh_cnt == '0) x0_q <= blk_x0;
            sh_cnt <= (sh_cnt == CNT_W'(LAST - 1)) ? '0 : sh_cnt + 1'b1;
        end
    end

    // Track the row and beat of the centre beat that is emitted next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orow  <= '0;
            obeat <= '0;
        end else if (emit) begin
            if (obeat == BEAT_W'(NB - 1)) begin
                obeat <= '0;
                orow  <= (orow == ROW_W'(GRID_H - 1)) ? '0 : orow + 1'b1;
            end else begin
                obeat <= obeat + 1'b1;
            end
        end
    end

    // Output register: load on emit, release when downstream takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_mask  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_data  <= res_n;
            out_mask  <= ok_n;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    stencil_rowbuf #(.BW(BW), .R(R), .NB(NB)) u_rowbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift),
        .din   (din),
        .win   (win)
    );

    for (genvar l = 0; l < V; l++) begin : g_lane
        logic [4*R*DW-1:0] nb;
        logic [4*R-1:0]    nok;
        logic [4*R-1:0]    nin;
        logic              lok;

        for (genvar d = 1; d <= R; d++) begin : g_dist
            if (l - d >= 0) begin : g_wc
                assign nb[slot_w(d)*DW +: DW] = win[0*BW + (l-d)*DW +: DW];
                assign nok[slot_w(d)]         = win[0*BW + V*DW + (l-d)];
            end else begin : g_wp
                assign nb[slot_w(d)*DW +: DW] = win[1*BW + (V+l-d)*DW +: DW];
                assign nok[slot_w(d)]         = win[1*BW + V*DW + (V+l-d)];
            end
            if (l + d < V) begin : g_ec
                assign nb[slot_e(d)*DW +: DW] = win[0*BW + (l+d)*DW +: DW];
                assign nok[slot_e(d)]         = win[0*BW + V*DW + (l+d)];
            end else begin : g_en
                assign nb[slot_e(d)*DW +: DW] = win[2*BW + (l+d-V)*DW +: DW];
                assign nok[slot_e(d)]         = win[2*BW + V*DW + (l+d-V)];
            end
            assign nb[slot_n(d)*DW +: DW] = win[(1+2*d)*BW + l*DW +: DW];
            assign nok[slot_n(d)]         = win[(1+2*d)*BW + V*DW + l];
            assign nb[slot_s(d)*DW +: DW] = win[(2+2*d)*BW + l*DW +: DW];
            assign nok[slot_s(d)]         = win[(2+2*d)*BW + V*DW + l];
        end

        // Decide which horizontal neighbours lie inside block and grid, and lane trust.
        always_comb begin
            int col, gx;
            col = int'(obeat) * V + l;
            gx  = int'(x0_q) + col;
            lok = (gx >= 0) && (gx < GRID_W) && (col >= R) && (col < BLK_W - R);
            for (int d = 1; d <= R; d++) begin
                nin[slot_w(d)] = (col - d >= 0) && (gx - d >= 0);
                nin[slot_e(d)] = (col + d < BLK_W) && (gx + d < GRID_W);
                nin[slot_n(d)] = 1'b1;
                nin[slot_s(d)] = 1'b1;
            end
        end

        stencil_lane #(.DW(DW), .CW(CW), .R(R)) u_lane (
            .ctr      (win[0*BW + l*DW +: DW]),
            .ctr_ok   (win[0*BW + V*DW + l]),
            .nbr      (nb),
            .nbr_ok   (nok),
            .nbr_in   (nin),
            .edge_row (edge_row),
            .lane_ok  (lok),
            .coef     (coef),
            .res      (res_n[l*DW +: DW]),
            .res_ok   (ok_n[l])
        );
    end
endmodule

// File: rtl/stencil_pe_chk.sv
// Property checker for stencil_pe, attached by bind. It keeps its own
// output beat counter to know which block columns are leaving.
module stencil_pe_chk #(
    parameter int DW    = 16,
    parameter int V     = 2,
    parameter int R     = 1,
    parameter int BLK_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [V*DW-1:0] out_data,
    input logic [V-1:0]    out_mask
);
    localparam int NB     = BLK_W / V;
    localparam int BEAT_W = $clog2(NB + 1);

    logic [BEAT_W-1:0] ob;
    logic [V-1:0]      halo;

    // Count output beats taken, modulo the beats in one row.
    always_ff @(posedge clk) begin
        if (!rst_n) ob <= '0;
        else if (out_valid && out_ready) ob <= (ob == BEAT_W'(NB - 1)) ? '0 : ob + 1'b1;
    end

    // Lanes of the current beat that sit in the block halo.
    always_comb begin
        for (int l = 0; l < V; l++) begin
            halo[l] = (int'(ob) * V + l < R) || (int'(ob) * V + l >= BLK_W - R);
        end
    end

    AST_HALO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & halo) == '0)); // R5
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mask))); // R8
    AST_NO_INTAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R8
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready)); // R10
endmodule

bind stencil_pe stencil_pe_chk #(.DW(DW), .V(V), .R(R), .BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_mask  (out_mask)
);

// File: tb/tb_stencil_pe.sv
// Self-checking bench: a table of block runs, then directed reset and
// trust-propagation cases. Inputs are driven and outputs sampled at negedge.
module tb_stencil_pe;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, CW = 16, V = 2, R = 1, BLK_W = 8, GRID_W = 12, GRID_H = 5, XW = 16;
    localparam int NB   = BLK_W / V;
    localparam int TOT  = GRID_H * NB;
    localparam int NTAP = 4 * R + 1;
    localparam int FILL = R * NB + 2;
    localparam int NCASE = 7;
    // x0, data seed, coefficient set, stall pattern
    localparam int TBL [NCASE][4] = '{
        '{0, 0, 0, 0}, '{6, 1, 1, 0}, '{0, 2, 1, 1}, '{-1, 3, 2, 0},
        '{6, 4, 2, 1}, '{2, 1, 0, 1}, '{-1, 1, 1, 1}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [V*DW-1:0] in_data = '0, out_data;
    logic [V-1:0] in_mask = '0, out_mask;
    logic signed [XW-1:0] blk_x0 = '0;
    logic [NTAP*CW-1:0] coef = '0;

    int D [GRID_H][BLK_W];
    bit M [GRID_H][BLK_W];
    int K [NTAP];
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stencil_pe #(.DW(DW), .CW(CW), .V(V), .R(R), .BLK_W(BLK_W), .GRID_W(GRID_W),
                 .GRID_H(GRID_H), .XW(XW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mask(in_mask), .blk_x0(blk_x0), .coef(coef),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_mask(out_mask));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int gval(input int seed, input int y, input int gx);
        if (seed == 3) return 30000;
        if (seed == 4) return -30000 + gx * 7;
        return (((y * 37 + gx * 11 + seed * 53) % 97) - 48) * 97;
    endfunction

    function automatic bit ingrid(input int gx);
        return gx >= 0 && gx < GRID_W;
    endfunction

    function automatic bit wuse(input int x0, input int c, input int d);
        return (c - d >= 0) && ingrid(x0 + c - d);
    endfunction

    function automatic bit euse(input int x0, input int c, input int d);
        return (c + d < BLK_W) && ingrid(x0 + c + d);
    endfunction

    function automatic bit edge_row(input int y);
        return y < R || y >= GRID_H - R;
    endfunction

    // Reference result per R1..R4.
    function automatic int expv(input int x0, input int y, input int c);
        longint acc, q;
        int d0;
        d0 = D[y][c];
        if (edge_row(y)) return d0;
        acc = longint'(K[0]) * d0;
        for (int d = 1; d <= R; d++) begin
            acc += longint'(K[4*(d-1)+1]) * (wuse(x0, c, d) ? D[y][c-d] : d0);
            acc += longint'(K[4*(d-1)+2]) * (euse(x0, c, d) ? D[y][c+d] : d0);
            acc += longint'(K[4*(d-1)+3]) * D[y-d][c];
            acc += longint'(K[4*(d-1)+4]) * D[y+d][c];
        end
        q = (acc + (64'sd1 <<< (CW - 3))) >>> (CW - 2);
        if (q > 32767) return 32767;
        if (q < -32768) return -32768;
        return int'(q);
    endfunction

    // Reference trust flag per R5 and R6.
    function automatic bit emask(input int x0, input int y, input int c);
        bit ok;
        ok = M[y][c] && ingrid(x0 + c) && c >= R && c < BLK_W - R;
        if (!edge_row(y)) begin
            for (int d = 1; d <= R; d++) begin
                if (wuse(x0, c, d)) ok &= M[y][c-d];
                if (euse(x0, c, d)) ok &= M[y][c+d];
                ok &= M[y-d][c] && M[y+d][c];
            end
        end
        return ok;
    endfunction

    task automatic load(input int x0, input int seed, input int cs);
        for (int y = 0; y < GRID_H; y++)
            for (int c = 0; c < BLK_W; c++) begin
                D[y][c] = gval(seed, y, x0 + c);
                M[y][c] = ingrid(x0 + c);
            end
        for (int t = 0; t < NTAP; t++) begin
            if (cs == 0)      K[t] = (t == 0) ? 8192 : 8192 / (4 * R);
            else if (cs == 1) K[t] = ((t * 1237) % 9000) - 3000;
            else              K[t] = 16384;
            coef[t*CW +: CW] = CW'(K[t]);
        end
    endtask

    task automatic run_block(input int x0, input int cs, input int stall, input bit timing,
                             input string mtag);
        int ni = 0, no = 0, cyc = 0;
        bit seen = 0, drained = 0, held = 0;
        logic [V*DW-1:0] hd;
        while (no < TOT && cyc < 3000) begin
            @(negedge clk);
            in_valid  = (ni < TOT) && (stall == 0 || cyc % 3 != 1);
            out_ready = (stall == 0) || (cyc % 4 != 2);
            blk_x0    = (ni == 0) ? XW'(x0) : XW'(16'sh05A5);  // R9: later values ignored
            if (ni < TOT)
                for (int l = 0; l < V; l++) begin
                    in_data[l*DW +: DW] = DW'(D[ni / NB][(ni % NB) * V + l]);
                    in_mask[l]          = M[ni / NB][(ni % NB) * V + l];
                end
            #1;
            if (held) chk(out_valid && out_data == hd, "R8 held beat", int'(out_data), int'(hd));
            held = out_valid && !out_ready;
            hd   = out_data;
            if (timing && !seen && out_valid) begin
                chk(ni == FILL + 1, "R7 first result latency", ni, FILL + 1);
                seen = 1;
            end
            if (timing && ni == TOT && !drained) begin
                chk(in_ready == 1'b0, "R9 intake closed while draining", int'(in_ready), 0);
                drained = 1;
            end
            if (in_valid && in_ready) ni++;
            if (out_valid && out_ready) begin
                for (int l = 0; l < V; l++) begin
                    int y, c, ev, av;
                    bit em;
                    string tg;
                    y  = no / NB;
                    c  = (no % NB) * V + l;
                    em = emask(x0, y, c);
                    chk(out_mask[l] == em, mtag, int'(out_mask[l]), int'(em));
                    if (em) begin
                        ev = expv(x0, y, c);
                        av = int'($signed(out_data[l*DW +: DW]));
                        if (edge_row(y)) tg = "R4 edge row";
                        else if (!wuse(x0, c, R) || !euse(x0, c, R)) tg = "R3 clamp";
                        else if (cs == 2) tg = "R2 saturation";
                        else tg = "R1/R7 weighted sum";
                        chk(av == ev, tg, av, ev);
                    end
                end
                no++;
            end
            cyc++;
        end
        chk(no == TOT, "R7 beat count", no, TOT);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R10 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;

        for (int i = 0; i < NCASE; i++) begin
            load(TBL[i][0], TBL[i][1], TBL[i][2]);
            run_block(TBL[i][0], TBL[i][2], TBL[i][3], TBL[i][3] == 0, "R5 lane mask");
        end

        // Directed: reset in the middle of a block, then a clean block.
        load(0, 1, 0);
        @(negedge clk);
        in_valid = 1'b1;
        out_ready = 1'b1;
        repeat (9) @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10 mid-block reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R10 mid-block reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        run_block(0, 0, 0, 1'b1, "R5 lane mask after reset");

        // Directed: one untrusted cell spreads to its neighbours.
        load(0, 1, 1);
        M[2][3] = 1'b0;
        run_block(0, 1, 1, 1'b0, "R6 trust propagation");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule